// File: doc/BRIEF.md
# Page-Table Write Tracker for Selective TLB Invalidation

This block sits next to a translation lookaside buffer and allows translations that belong to several address spaces to stay resident across context switches. Each tracker slot is bound to one TLB entry. When the page walker fills an entry, the tracker stores the word address in physical memory that the page-table entry was read from, together with the page-table base that was active at that time. The base tag means a lookup only hits entries of the current address space, so switching spaces does not require any invalidation.

The tracker also watches every memory write, including writes to the page tables of address spaces that are not running. A write that lands on a recorded word does not remove the entry at once. Instead, it sets a stale flag on that slot. When the TLB next requests a flush, only the stale slots are invalidated, and every untouched translation survives. A separate flush-all input discards everything. It is used when the tracked state cannot be trusted.

The fill port and the write-snoop port are valid/ready streams. The snoop port never applies back-pressure: `wr_ready_o` is always high, so every write presented with `wr_valid_i` is observed in that cycle. The fill port refuses a beat only in a cycle where flush-all is requested. A fill beat is taken when `fill_valid_i && fill_ready_o`. Flush requests and the invalidate output are plain single-cycle control pins.

Top module: `pt_flush_tracker`

## Requirements
- R1: After reset, every slot is empty and no slot is stale. `inval_valid_o` is 0, `inval_vec_o` is 0, `resident_o` is 0, and both `fill_ready_o` and `wr_ready_o` are 1.
- R2: An accepted fill to slot `fill_slot_i` makes that slot valid with a clear stale flag. The slot records `fill_waddr_i` and `fill_base_i`, and the new state is visible from the following cycle.
- R3: A snooped write whose word address equals the recorded address of a valid slot, and whose byte enable `wr_be_i` has at least one bit set, sets that slot's stale flag. The slot stays valid and resident until a flush.
- R4: The write match ignores the slot's base tag and `cur_base_i`. Writes to the page tables of inactive address spaces mark their slots in the same way.
- R5: A write with `wr_be_i` equal to 0, a write to a different word address, or a write to an empty slot leaves the stale flags unchanged.
- R6: When `flush_i` is high at a clock edge, the next cycle shows `inval_valid_o`=1 and `inval_vec_o` bit i set exactly for slots that were stale before that edge. Those slots become empty and not stale. All other slots keep their contents.
- R7: When a fill and a matching write target the same slot in one cycle, the fill wins and the slot's stale flag is clear.
- R8: When `flush_all_i` is high, `fill_ready_o` is 0 in that cycle. The next cycle shows `inval_valid_o`=1 with every bit of `inval_vec_o` set, and all slots are empty.
- R9: A write that matches in the same cycle as `flush_i` is not applied to that flush. The slot's stale flag is set afterwards, and the slot is invalidated by the following flush.
- R10: A slot that is refilled in the same cycle as `flush_i` is left out of that invalidate vector, even if it was stale. It holds the new translation with a clear stale flag.
- R11: `resident_o` bit i is 1 exactly when slot i is valid and its base tag equals `cur_base_i`.
- R12: `wr_ready_o` is always 1. `inval_vec_o` is 0 whenever `inval_valid_o` is 0, and `inval_valid_o` is 1 only in the cycle after a flush or flush-all request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_valid_i | input | 1 | Fill beat present |
| fill_ready_o | output | 1 | Fill beat accepted when high together with valid |
| fill_slot_i | input | SLOT_W (4) | TLB entry / tracker slot being filled |
| fill_waddr_i | input | PADDR_W-2 (30) | Word address the page-table entry was read from |
| fill_base_i | input | BASE_W (20) | Page-table base active at fill time |
| wr_valid_i | input | 1 | Snooped memory write present |
| wr_ready_o | output | 1 | Always high, no back-pressure on snooping |
| wr_waddr_i | input | PADDR_W-2 (30) | Word address of the snooped write |
| wr_be_i | input | 4 | Byte enables of the snooped write |
| flush_i | input | 1 | Selective flush request |
| flush_all_i | input | 1 | Unconditional flush of every slot |
| cur_base_i | input | BASE_W (20) | Page-table base of the running address space |
| inval_valid_o | output | 1 | Invalidate vector is meaningful this cycle |
| inval_vec_o | output | N_SLOTS (16) | One bit per TLB entry to invalidate |
| resident_o | output | N_SLOTS (16) | Slots valid for the current address space |

## Verification
Two pairs of events can fall in the same cycle, and both are driven deliberately. The first pair is a fill together with a snooped write to the same word and slot. The second is a matching write arriving in the cycle of a flush, and its mirror case, a refill of a stale slot during a flush. Each collision is first provoked by a directed case. The bench then follows it with a flush, so the outcome shows up in the invalidate vector, which is the only place the stale flags can be observed. The random phase draws addresses from a pool of eight words so that these collisions recur often. A bench model built from the requirements predicts the vector and the resident mask on every cycle.

// File: rtl/pftk_pkg.sv
package pftk_pkg;
  // Byte-offset bits dropped from a physical address to form a word address.
  localparam int unsigned BYTE_OFS_W = 2;
  localparam int unsigned BE_W       = 1 << BYTE_OFS_W;

  typedef enum logic [1:0] {
    FL_NONE  = 2'd0,
    FL_STALE = 2'd1,
    FL_ALL   = 2'd2
  } flush_kind_e;
endpackage

// File: rtl/pftk_fill_decode.sv
module pftk_fill_decode #(
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned SLOT_W  = 4
) (
  input  logic              en_i,
  input  logic [SLOT_W-1:0] idx_i,
  output logic [N_SLOTS-1:0] mask_o
);
  for (genvar g = 0; g < N_SLOTS; g++) begin : g_dec
    assign mask_o[g] = en_i && (idx_i == SLOT_W'(g));
  end

  always_comb begin
    assert ($onehot0(mask_o)) else $error("assert_fill_onehot_R2 failed");
  end
endmodule

// File: rtl/pftk_slot.sv
module pftk_slot #(
  parameter int unsigned WA_W   = 30,
  parameter int unsigned BASE_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_hit_i,
  input  logic [WA_W-1:0]   fill_waddr_i,
  input  logic [BASE_W-1:0] fill_base_i,
  input  logic              wr_en_i,
  input  logic [WA_W-1:0]   wr_waddr_i,
  input  logic              flush_i,
  input  logic              flush_all_i,
  input  logic [BASE_W-1:0] cur_base_i,
  output logic              valid_o,
  output logic              stale_o,
  output logic              resident_o
);
  logic              valid_q, stale_q;
  logic [WA_W-1:0]   waddr_q;
  logic [BASE_W-1:0] base_q;
  logic              wr_hit, drop_now;

  assign wr_hit   = valid_q && wr_en_i && (waddr_q == wr_waddr_i);
  assign drop_now = flush_i && stale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      stale_q <= 1'b0;
      waddr_q <= '0;
      base_q  <= '0;
    end else if (flush_all_i) begin
      valid_q <= 1'b0;
      stale_q <= 1'b0;
    end else if (fill_hit_i) begin
      valid_q <= 1'b1;
      stale_q <= 1'b0;
      waddr_q <= fill_waddr_i;
      base_q  <= fill_base_i;
    end else if (drop_now) begin
      valid_q <= 1'b0;
      stale_q <= 1'b0;
    end else if (wr_hit) begin
      stale_q <= 1'b1;
    end
  end

  assign valid_o    = valid_q;
  assign stale_o    = stale_q;
  assign resident_o = valid_q && (base_q == cur_base_i);

  // R7: a fill always leaves a clean, valid slot
  assert_fill_clean_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_hit_i |=> (valid_o && !stale_o));
  // R6: a stale slot is dropped by a selective flush
  assert_flush_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && stale_o && !fill_hit_i && !flush_all_i) |=> !valid_o);
  // R3: a matching write marks the slot
  assert_mark_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_hit && !fill_hit_i && !flush_all_i && !drop_now) |=> (stale_o && valid_o));
  // R8: flush-all empties the slot
  assert_flush_all_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (!valid_o && !stale_o));
  // R6: a stale flag never outlives its entry
  assert_stale_valid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stale_o |-> valid_o);
endmodule

// File: rtl/pftk_flush_ctrl.sv
module pftk_flush_ctrl
  import pftk_pkg::*;
#(
  parameter int unsigned N_SLOTS = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               flush_all_i,
  input  logic [N_SLOTS-1:0] stale_vec_i,
  input  logic [N_SLOTS-1:0] fill_mask_i,
  output logic               inval_valid_o,
  output logic [N_SLOTS-1:0] inval_vec_o
);
  flush_kind_e       kind;
  logic [N_SLOTS-1:0] vec_d;

  always_comb begin
    if (flush_all_i)  kind = FL_ALL;
    else if (flush_i) kind = FL_STALE;
    else              kind = FL_NONE;
  end

  always_comb begin
    unique case (kind)
      FL_ALL:   vec_d = '1;
      FL_STALE: vec_d = stale_vec_i & ~fill_mask_i;
      default:  vec_d = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inval_valid_o <= 1'b0;
      inval_vec_o   <= '0;
    end else begin
      inval_valid_o <= (kind != FL_NONE);
      inval_vec_o   <= vec_d;
    end
  end

  // R12: quiet vector outside a flush pulse
  assert_vec_quiet_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inval_valid_o |-> (inval_vec_o == '0));
  // R8: flush-all reports every entry
  assert_all_ones_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (inval_valid_o && (&inval_vec_o)));
  // R10: a slot refilled during the flush is not reported
  assert_refill_spared_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_i && !flush_all_i) |=> ((inval_vec_o & $past(fill_mask_i)) == '0));
endmodule

// File: rtl/pt_flush_tracker.sv
module pt_flush_tracker
  import pftk_pkg::*;
#(
  parameter int unsigned N_SLOTS = 16,
  parameter int unsigned PADDR_W = 32,
  parameter int unsigned BASE_W  = 20,
  localparam int unsigned SLOT_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1,
  localparam int unsigned WA_W   = PADDR_W - BYTE_OFS_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               fill_valid_i,
  output logic               fill_ready_o,
  input  logic [SLOT_W-1:0]  fill_slot_i,
  input  logic [WA_W-1:0]    fill_waddr_i,
  input  logic [BASE_W-1:0]  fill_base_i,
  input  logic               wr_valid_i,
  output logic               wr_ready_o,
  input  logic [WA_W-1:0]    wr_waddr_i,
  input  logic [BE_W-1:0]    wr_be_i,
  input  logic               flush_i,
  input  logic               flush_all_i,
  input  logic [BASE_W-1:0]  cur_base_i,
  output logic               inval_valid_o,
  output logic [N_SLOTS-1:0] inval_vec_o,
  output logic [N_SLOTS-1:0] resident_o
);
  logic               fill_acc, wr_en;
  logic [N_SLOTS-1:0] fill_mask, valid_vec, stale_vec;

  assign fill_ready_o = !flush_all_i;
  assign wr_ready_o   = 1'b1;
  assign fill_acc     = fill_valid_i && fill_ready_o;
  assign wr_en        = wr_valid_i && (|wr_be_i);

  pftk_fill_decode #(.N_SLOTS(N_SLOTS), .SLOT_W(SLOT_W)) u_dec (
    .en_i  (fill_acc),
    .idx_i (fill_slot_i),
    .mask_o(fill_mask)
  );

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    pftk_slot #(.WA_W(WA_W), .BASE_W(BASE_W)) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .fill_hit_i  (fill_mask[s]),
      .fill_waddr_i(fill_waddr_i),
      .fill_base_i (fill_base_i),
      .wr_en_i     (wr_en),
      .wr_waddr_i  (wr_waddr_i),
      .flush_i     (flush_i),
      .flush_all_i (flush_all_i),
      .cur_base_i  (cur_base_i),
      .valid_o     (valid_vec[s]),
      .stale_o     (stale_vec[s]),
      .resident_o  (resident_o[s])
    );
  end

  pftk_flush_ctrl #(.N_SLOTS(N_SLOTS)) u_flush (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .flush_all_i  (flush_all_i),
    .stale_vec_i  (stale_vec),
    .fill_mask_i  (fill_mask),
    .inval_valid_o(inval_valid_o),
    .inval_vec_o  (inval_vec_o)
  );

  // R11: residency is a subset of valid slots
  assert_resident_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resident_o & ~valid_vec) == '0);
  // R12: write port never stalls
  assert_wr_ready_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_i |-> wr_ready_o);
endmodule

// File: tb/pt_flush_tracker_tb_top.sv
module pt_flush_tracker_tb_top;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fill_valid = 1'b0;
  logic        fill_ready;
  logic [3:0]  fill_slot = '0;
  logic [29:0] fill_waddr = '0;
  logic [19:0] fill_base = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [29:0] wr_waddr = '0;
  logic [3:0]  wr_be = '0;
  logic        flush = 1'b0;
  logic        flush_all = 1'b0;
  logic [19:0] cur_base = '0;
  logic        inval_valid;
  logic [N-1:0] inval_vec, resident;

  always #4 clk = ~clk;

  pt_flush_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .fill_valid_i(fill_valid), .fill_ready_o(fill_ready), .fill_slot_i(fill_slot),
    .fill_waddr_i(fill_waddr), .fill_base_i(fill_base),
    .wr_valid_i(wr_valid), .wr_ready_o(wr_ready), .wr_waddr_i(wr_waddr), .wr_be_i(wr_be),
    .flush_i(flush), .flush_all_i(flush_all), .cur_base_i(cur_base),
    .inval_valid_o(inval_valid), .inval_vec_o(inval_vec), .resident_o(resident)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  logic        m_v [N];
  logic        m_s [N];
  logic [29:0] m_a [N];
  logic [19:0] m_b [N];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s got=%h exp=%h", tag, what, got, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_resident(input logic [19:0] cb);
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i] = m_v[i] && (m_b[i] == cb);
    return r;
  endfunction

  function automatic logic [N-1:0] exp_stale();
    logic [N-1:0] r = '0;
    for (int i = 0; i < N; i++) r[i] = m_s[i];
    return r;
  endfunction

  task automatic step(input bit fv, input int fs, input logic [29:0] fa, input logic [19:0] fb,
                      input bit wv, input logic [29:0] wa, input logic [3:0] be,
                      input bit fl, input bit fall, input string tag);
    logic [N-1:0] fm, ev;
    bit evv, wen;
    @(negedge clk);
    fill_valid = fv; fill_slot = 4'(fs); fill_waddr = fa; fill_base = fb;
    wr_valid = wv; wr_waddr = wa; wr_be = be; flush = fl; flush_all = fall;
    #1;
    chk(fill_ready === !fall, "R8", "fill_ready", 32'(fill_ready), 32'(!fall));
    chk(wr_ready === 1'b1, "R12", "wr_ready", 32'(wr_ready), 32'd1);
    fm  = (fv && !fall) ? (N'(1) << fs) : '0;
    evv = fl || fall;
    ev  = fall ? '1 : (fl ? (exp_stale() & ~fm) : '0);
    wen = wv && (be != 4'd0);
    for (int i = 0; i < N; i++) begin
      if (fall) begin
        m_v[i] = 0; m_s[i] = 0;
      end else if (fm[i]) begin
        m_v[i] = 1; m_s[i] = 0; m_a[i] = fa; m_b[i] = fb;
      end else if (fl && m_s[i]) begin
        m_v[i] = 0; m_s[i] = 0;
      end else if (m_v[i] && wen && m_a[i] == wa) begin
        m_s[i] = 1;
      end
    end
    @(posedge clk); #1;
    chk(inval_valid === evv && inval_vec === ev, tag, "inval",
        {15'd0, inval_valid, inval_vec}, {15'd0, evv, ev});
    chk(resident === exp_resident(cur_base), tag, "resident",
        32'(resident), 32'(exp_resident(cur_base)));
  endtask

  task automatic idle(input string tag);
    step(0, 0, '0, '0, 0, '0, 4'd0, 0, 0, tag);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  localparam logic [29:0] A0 = 30'h0400_0000, A1 = 30'h0400_0001, A2 = 30'h0400_0002,
                          A3 = 30'h0400_0003, A5 = 30'h0400_0005;
  localparam logic [19:0] B0 = 20'h00A10, B1 = 20'h00B20, B2 = 20'h00C30;

  initial begin
    logic [29:0] pool [8];
    logic [19:0] bases [3];
    void'($urandom(32'h1357_2468));
    for (int i = 0; i < N; i++) begin m_v[i] = 0; m_s[i] = 0; m_a[i] = '0; m_b[i] = '0; end
    for (int k = 0; k < 8; k++) pool[k] = A0 + 30'(k);
    bases[0] = B0; bases[1] = B1; bases[2] = B2;

    repeat (3) @(posedge clk);
    #1;
    chk(inval_valid === 1'b0 && inval_vec === '0, "R1", "inval in reset", 32'(inval_vec), 0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk(resident === '0, "R1", "resident", 32'(resident), 0);
    chk(fill_ready === 1'b1 && wr_ready === 1'b1, "R1", "ready", {fill_ready, wr_ready}, 2'b11);
    chk(inval_valid === 1'b0 && inval_vec === '0, "R1", "inval", 32'(inval_vec), 0);

    cur_base = B0;
    step(1, 0, A0, B0, 0, '0, 0, 0, 0, "R2");
    step(1, 1, A1, B1, 0, '0, 0, 0, 0, "R11");
    step(1, 2, A2, B0, 0, '0, 0, 0, 0, "R2");
    step(0, 0, '0, '0, 1, A1, 4'b0100, 0, 0, "R4");
    step(0, 0, '0, '0, 1, A0, 4'b0000, 0, 0, "R5");
    step(0, 0, '0, '0, 1, A3, 4'b1111, 0, 0, "R5");
    step(0, 0, '0, '0, 1, A0 + 30'h100, 4'b0001, 0, 0, "R5");
    step(0, 0, '0, '0, 0, '0, 0, 1, 0, "R6");          // only slot 1 reported
    idle("R12");
    cur_base = B1;
    idle("R11");
    cur_base = B0;
    step(0, 0, '0, '0, 1, A0, 4'b0001, 1, 0, "R9");    // slot 0 not yet stale
    step(0, 0, '0, '0, 0, '0, 0, 1, 0, "R9");          // now slot 0 goes
    step(1, 0, A0, B0, 0, '0, 0, 0, 0, "R2");
    step(0, 0, '0, '0, 1, A2, 4'b1000, 0, 0, "R3");    // slot 2 stale, still resident
    step(1, 2, A5, B0, 1, A5, 4'b0010, 0, 0, "R7");
    step(0, 0, '0, '0, 0, '0, 0, 1, 0, "R7");          // nothing stale
    step(0, 0, '0, '0, 1, A5, 4'b0001, 0, 0, "R3");
    step(1, 2, A3, B0, 0, '0, 0, 1, 0, "R10");         // refill wins over flush
    step(0, 0, '0, '0, 0, '0, 0, 1, 0, "R10");
    step(1, 4, A1, B2, 1, A0, 4'b1111, 0, 1, "R8");
    idle("R8");

    for (int n = 0; n < 3000; n++) begin
      if ($urandom % 40 == 0) cur_base = bases[$urandom % 3];
      step(($urandom % 3) == 0, int'($urandom % 16), pool[$urandom % 8], bases[$urandom % 3],
           ($urandom % 2) == 1, pool[$urandom % 8], 4'($urandom % 16),
           ($urandom % 6) == 0, ($urandom % 97) == 0, "rand_R6");
    end
    idle("R12");
    finish_run();
  end
endmodule